// File: doc/BRIEF.md
# Grouped NMI/IRQ Interrupt Aggregator

This block is the interrupt front end of a small 8-bit controller. It gathers eighteen event sources and gives each one a sticky pending flag. One source is a timer wrap. Two are external pins with selectable edge polarity, and one is a vsync pin. The rest are single-cycle strobes: an auto-mute event, an A/D-done event, and six events from each of two display-data serial channels. The flags fall into two classes. One is a non-maskable pair: external pin 0 and auto-mute. The other is a maskable class made of three subgroups. The block drives the CPU's NMI and IRQ request lines and the vector address that matches the request being served.

Software reads the flags through a small read port, one byte per group. It clears a flag by writing a 1 to that bit position. Per-source enable bits decide which pending flags may raise a request. The CPU's interrupt-mask flag gates only the maskable line. The pins enter through a synchronizer, so they may be fully asynchronous to the clock. The strobes and the timer count are assumed to be synchronous to the clock already.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is active, every pending flag reads 0, `nmi_req` and `irq_req` are 0, `irq_sub` is 0 and `vec_addr` is 0xFFFE.
- R2: If a strobe input (`mute_evt`, `adc_done`, any bit of `ch0_ev` or `ch1_ev`) is high at a rising clock edge, its pending flag reads 1 after that edge.
- R3: The external pins pass through a two-stage synchronizer. The active edge of a pin is rising when its select input (`ext0_rise`, `ext1_rise`) is 1 and falling when it is 0. An active edge sets the pending flag at the third rising clock edge after the pin changes. The opposite edge sets nothing.
- R4: A rising edge on `vsync_pin` sets its pending flag, with the same latency as R3. A falling edge sets nothing.
- R5: The timer flag is set at a clock edge when `tmr_cnt` is 0x00 and was 0xFF at the previous edge. No other change of `tmr_cnt` sets it.
- R6: When `wr_en` is high at a clock edge, every pending bit of group `wr_addr` whose `wr_data` bit is 1 is cleared, and every other bit keeps its value. If a flag is cleared and set at the same edge, the set wins.
- R7: `irq_sub[g]` is 1 when subgroup g (0 = channel 0, 1 = channel 1, 2 = misc) has any pending flag whose enable bit is set. `irq_req` is the OR of `irq_sub`, forced to 0 while `cpu_imask` is 1.
- R8: `nmi_req` is high for exactly the one cycle after an edge at which an enabled non-maskable flag goes from 0 to 1. It ignores `cpu_imask`. An event on a flag that is already pending, or whose enable bit is 0, produces no pulse.
- R9: `vec_addr` is 0xFFFA while any enabled non-maskable flag is pending, and 0xFFFE otherwise.
- R10: `rd_data` shows the pending flags of group `rd_addr`, and unused bits read 0. The layout is: address 0 holds external-0 in bit 0 and mute in bit 1. Addresses 1 and 2 hold channel 0 and channel 1 in bits 5:0, in the same order as `ch0_ev` and `ch1_ev`. Address 3 holds A/D-done in bit 0, vsync in bit 1, external-1 in bit 2 and timer in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext0_pin | input | 1 | External interrupt pin 0, asynchronous |
| ext1_pin | input | 1 | External interrupt pin 1, asynchronous |
| vsync_pin | input | 1 | Vertical sync input, asynchronous |
| mute_evt | input | 1 | Auto-mute event strobe |
| adc_done | input | 1 | A/D conversion finished strobe |
| tmr_cnt | input | 8 | Base timer count value |
| ch0_ev | input | 6 | Channel 0 event strobes |
| ch1_ev | input | 6 | Channel 1 event strobes |
| ext0_rise | input | 1 | Pin 0 edge select: 1 rising, 0 falling |
| ext1_rise | input | 1 | Pin 1 edge select: 1 rising, 0 falling |
| nmi_en | input | 2 | Non-maskable source enables |
| ch0_en | input | 6 | Channel 0 source enables |
| ch1_en | input | 6 | Channel 1 source enables |
| misc_en | input | 4 | Misc subgroup source enables |
| cpu_imask | input | 1 | CPU interrupt-mask flag |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_addr | input | 2 | Group addressed by the clear |
| wr_data | input | 8 | Clear mask |
| rd_addr | input | 2 | Group shown on rd_data |
| rd_data | output | 8 | Pending flags of the selected group |
| nmi_req | output | 1 | Non-maskable request pulse |
| irq_req | output | 1 | Maskable request level |
| irq_sub | output | 3 | Per-subgroup maskable request |
| vec_addr | output | 16 | Vector address for the active request |

## Verification
The bench uses the default parameters: a two-stage synchronizer, an 8-bit timer count and 8-bit register data. With an 8-bit count, a wrap comes within reach every 256 increments. The random phase also jumps the count to 0xFE often, so wraps happen many times and sometimes coincide with a clear of the same flag. Directed passes drive each pin in both polarities and pin down the three-edge latency. The random phase checks the mask, the enables, and the no-second-pulse rule for NMI against a cycle model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NMI_N  = 2;
  localparam int CH_N   = 6;
  localparam int MISC_N = 4;

  typedef enum logic [1:0] {
    GRP_NMI  = 2'd0,
    GRP_CH0  = 2'd1,
    GRP_CH1  = 2'd2,
    GRP_MISC = 2'd3
  } grp_addr_e;

  localparam int NB_EXT0 = 0;
  localparam int NB_MUTE = 1;
  localparam int MB_ADC  = 0;
  localparam int MB_VSYN = 1;
  localparam int MB_EXT1 = 2;
  localparam int MB_TMR  = 3;

  localparam logic [15:0] VEC_NMI = 16'hFFFA;
  localparam logic [15:0] VEC_IRQ = 16'hFFFE;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol_rise,
  output logic evt
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  logic cur, prv;
  assign cur = sh_q[STAGES-1];
  assign prv = sh_q[STAGES];
  assign evt = pol_rise ? (cur & ~prv) : (~cur & prv);
endmodule

// File: rtl/irq_wrap_det.sv
module irq_wrap_det #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cnt,
  output logic          evt
);
  localparam logic [TW-1:0] TOP = {TW{1'b1}};
  logic [TW-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cnt;
  end

  assign evt = (prev_q == TOP) && (cnt == '0);
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] en,
  output logic [W-1:0] pend,
  output logic         fresh,
  output logic         req
);
  logic [W-1:0] pend_q, pend_d;
  logic         upd;

  always_comb begin
    pend_d = pend_q;
    if (clr_we) pend_d = pend_d & ~clr_mask;
    pend_d = pend_d | set;
  end

  assign upd = clr_we | (|set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  assign pend  = pend_q;
  assign fresh = |(set & ~pend_q & en);
  assign req   = |(pend_q & en);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TMR_W       = 8,
  parameter int DW          = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext0_pin,
  input  logic              ext1_pin,
  input  logic              vsync_pin,
  input  logic              mute_evt,
  input  logic              adc_done,
  input  logic [TMR_W-1:0]  tmr_cnt,
  input  logic [CH_N-1:0]   ch0_ev,
  input  logic [CH_N-1:0]   ch1_ev,
  input  logic              ext0_rise,
  input  logic              ext1_rise,
  input  logic [NMI_N-1:0]  nmi_en,
  input  logic [CH_N-1:0]   ch0_en,
  input  logic [CH_N-1:0]   ch1_en,
  input  logic [MISC_N-1:0] misc_en,
  input  logic              cpu_imask,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              nmi_req,
  output logic              irq_req,
  output logic [2:0]        irq_sub,
  output logic [15:0]       vec_addr
);
  localparam int NCH = 2;

  // pin front ends
  logic e0_evt, e1_evt, vs_evt, tmr_evt;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_e0 (
    .clk(clk), .rst_n(rst_n), .pin(ext0_pin), .pol_rise(ext0_rise), .evt(e0_evt));
  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_e1 (
    .clk(clk), .rst_n(rst_n), .pin(ext1_pin), .pol_rise(ext1_rise), .evt(e1_evt));
  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_vs (
    .clk(clk), .rst_n(rst_n), .pin(vsync_pin), .pol_rise(1'b1), .evt(vs_evt));
  irq_wrap_det #(.TW(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .cnt(tmr_cnt), .evt(tmr_evt));

  // non-maskable group
  logic [NMI_N-1:0] nmi_set, nmi_pend;
  logic             nmi_fresh, nmi_lvl;

  always_comb begin
    nmi_set          = '0;
    nmi_set[NB_EXT0] = e0_evt;
    nmi_set[NB_MUTE] = mute_evt;
  end

  irq_pend_bank #(.W(NMI_N)) u_nmi (
    .clk(clk), .rst_n(rst_n), .set(nmi_set),
    .clr_we(wr_en && (wr_addr == GRP_NMI)), .clr_mask(wr_data[NMI_N-1:0]),
    .en(nmi_en), .pend(nmi_pend), .fresh(nmi_fresh), .req(nmi_lvl));

  // channel subgroups
  logic [NCH-1:0][CH_N-1:0] ch_set, ch_en, ch_pend;
  logic [NCH-1:0]           ch_req;
  logic [NCH-1:0]           ch_fresh;

  assign ch_set = {ch1_ev, ch0_ev};
  assign ch_en  = {ch1_en, ch0_en};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    irq_pend_bank #(.W(CH_N)) u_bank (
      .clk(clk), .rst_n(rst_n), .set(ch_set[g]),
      .clr_we(wr_en && (wr_addr == 2'(g + 1))), .clr_mask(wr_data[CH_N-1:0]),
      .en(ch_en[g]), .pend(ch_pend[g]), .fresh(ch_fresh[g]), .req(ch_req[g]));
  end

  // misc subgroup
  logic [MISC_N-1:0] misc_set, misc_pend;
  logic              misc_fresh, misc_req;

  always_comb begin
    misc_set          = '0;
    misc_set[MB_ADC]  = adc_done;
    misc_set[MB_VSYN] = vs_evt;
    misc_set[MB_EXT1] = e1_evt;
    misc_set[MB_TMR]  = tmr_evt;
  end

  irq_pend_bank #(.W(MISC_N)) u_misc (
    .clk(clk), .rst_n(rst_n), .set(misc_set),
    .clr_we(wr_en && (wr_addr == GRP_MISC)), .clr_mask(wr_data[MISC_N-1:0]),
    .en(misc_en), .pend(misc_pend), .fresh(misc_fresh), .req(misc_req));

  // request outputs
  logic nmi_q, nmi_d;
  assign nmi_d = nmi_fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_q <= 1'b0;
    else        nmi_q <= nmi_d;
  end

  assign nmi_req  = nmi_q;
  assign irq_sub  = {misc_req, ch_req[1], ch_req[0]};
  assign irq_req  = ~cpu_imask & (|irq_sub);
  assign vec_addr = nmi_lvl ? VEC_NMI : VEC_IRQ;

  // read port
  always_comb begin
    rd_data = '0;
    unique case (grp_addr_e'(rd_addr))
      GRP_NMI:  rd_data[NMI_N-1:0]  = nmi_pend;
      GRP_CH0:  rd_data[CH_N-1:0]   = ch_pend[0];
      GRP_CH1:  rd_data[CH_N-1:0]   = ch_pend[1];
      GRP_MISC: rd_data[MISC_N-1:0] = misc_pend;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  tmr_cnt,
  input logic [1:0]  nmi_en,
  input logic [3:0]  misc_en,
  input logic        cpu_imask,
  input logic        nmi_req,
  input logic        irq_req,
  input logic [2:0]  irq_sub,
  input logic [15:0] vec_addr
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !cpu_imask);

  // R7
  irq_has_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_sub != 3'b000));

  // R8
  nmi_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && nmi_req) |-> ($past(nmi_en) != 2'b00));

  // R9
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_addr == 16'hFFFA) || (vec_addr == 16'hFFFE));

  // R5
  tmr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tmr_cnt == 8'h00 && $past(tmr_cnt) == 8'hFF && misc_en[3])
      |=> (!misc_en[3] || irq_sub[2]));
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (.*);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic ext0_pin, ext1_pin, vsync_pin, mute_evt, adc_done;
  logic [7:0] tmr_cnt;
  logic [5:0] ch0_ev, ch1_ev, ch0_en, ch1_en;
  logic ext0_rise, ext1_rise;
  logic [1:0] nmi_en;
  logic [3:0] misc_en;
  logic cpu_imask, wr_en;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic nmi_req, irq_req;
  logic [2:0] irq_sub;
  logic [15:0] vec_addr;

  irq_aggregator dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of pending flags
  logic [1:0] m_n;
  logic [5:0] m_c0, m_c1;
  logic [3:0] m_m;
  logic       m_nmi;
  logic [7:0] m_prev;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic idle();
    ext0_pin = 0; ext1_pin = 0; vsync_pin = 0; mute_evt = 0; adc_done = 0;
    tmr_cnt = 0; ch0_ev = 0; ch1_ev = 0; ext0_rise = 1; ext1_rise = 1;
    nmi_en = 0; ch0_en = 0; ch1_en = 0; misc_en = 0; cpu_imask = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    ticks(3);
    rst_n = 1;
    tick();
  endtask

  task automatic clr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0; wr_data = 0;
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {6'b0, m_n};
      2'd1: return {2'b0, m_c0};
      2'd2: return {2'b0, m_c1};
      default: return {4'b0, m_m};
    endcase
  endfunction

  function automatic logic [2:0] exp_sub();
    return {|(m_m & misc_en), |(m_c1 & ch1_en), |(m_c0 & ch0_en)};
  endfunction

  task automatic model_edge();
    logic [1:0] sn, cn;
    logic [5:0] s0, s1, c0, c1;
    logic [3:0] sm, cm;
    sn = {mute_evt, 1'b0};
    s0 = ch0_ev; s1 = ch1_ev;
    sm = {(m_prev == 8'hFF && tmr_cnt == 8'h00), 2'b00, adc_done};
    cn = (wr_en && wr_addr == 0) ? wr_data[1:0] : 2'b0;
    c0 = (wr_en && wr_addr == 1) ? wr_data[5:0] : 6'b0;
    c1 = (wr_en && wr_addr == 2) ? wr_data[5:0] : 6'b0;
    cm = (wr_en && wr_addr == 3) ? wr_data[3:0] : 4'b0;
    m_nmi = |(sn & ~m_n & nmi_en);
    m_n  = (m_n & ~cn) | sn;
    m_c0 = (m_c0 & ~c0) | s0;
    m_c1 = (m_c1 & ~c1) | s1;
    m_m  = (m_m & ~cm) | sm;
    m_prev = tmr_cnt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle();
    rst_n = 0;
    ticks(2);
    // R1 reset state
    chk("R1 nmi_req", nmi_req, 0);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 irq_sub", irq_sub, 0);
    chk("R1 vec_addr", vec_addr, 16'hFFFE);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1 chk("R1 rd_data", rd_data, 0);
    end
    rd_addr = 0;
    rst_n = 1;
    tick();

    // R3 pin 0 rising select, latency of three edges
    ext0_rise = 1; ext0_pin = 1;
    ticks(2);
    chk("R3 ext0 before latency", rd_data, 0);
    tick();
    chk("R3 ext0 rising set", rd_data, 8'h01);
    chk("R8 no pulse when disabled", nmi_req, 0);
    clr(2'd0, 8'h01);
    chk("R6 clear ext0", rd_data, 0);
    ext0_pin = 0;
    ticks(4);
    chk("R3 falling ignored when rising selected", rd_data, 0);

    // R3 pin 0 falling select with NMI enabled
    ext0_rise = 0; nmi_en = 2'b01; ext0_pin = 1;
    ticks(4);
    chk("R3 rising ignored when falling selected", rd_data, 0);
    ext0_pin = 0;
    ticks(2);
    chk("R8 no early pulse", nmi_req, 0);
    tick();
    chk("R3 ext0 falling set", rd_data, 8'h01);
    chk("R8 nmi pulse", nmi_req, 1);
    chk("R9 nmi vector", vec_addr, 16'hFFFA);
    cpu_imask = 1;
    tick();
    chk("R8 pulse one cycle", nmi_req, 0);
    chk("R9 vector held while pending", vec_addr, 16'hFFFA);
    cpu_imask = 0;
    clr(2'd0, 8'h03);
    chk("R9 vector back to irq", vec_addr, 16'hFFFE);
    nmi_en = 0;

    // R4 vsync rising only
    rd_addr = 3; vsync_pin = 1;
    ticks(3);
    chk("R4 vsync rising set", rd_data, 8'h02);
    clr(2'd3, 8'h02);
    vsync_pin = 0;
    ticks(4);
    chk("R4 vsync falling ignored", rd_data, 0);

    // R3 pin 1 falling select
    ext1_rise = 0; ext1_pin = 1;
    ticks(4);
    chk("R3 ext1 rising ignored", rd_data, 0);
    ext1_pin = 0;
    ticks(3);
    chk("R3 ext1 falling set", rd_data, 8'h04);
    misc_en = 4'b0100;
    #1 chk("R7 irq from ext1", irq_req, 1);
    cpu_imask = 1;
    #1 chk("R7 irq masked", irq_req, 0);
    chk("R7 sub unaffected by mask", irq_sub, 3'b100);

    // random phase with cycle model
    idle();
    do_reset();
    m_n = 0; m_c0 = 0; m_c1 = 0; m_m = 0; m_nmi = 0; m_prev = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      mute_evt  = ($urandom % 6) == 0;
      adc_done  = ($urandom % 8) == 0;
      ch0_ev    = 6'($urandom & $urandom & $urandom);
      ch1_ev    = 6'($urandom & $urandom & $urandom);
      if (($urandom % 24) == 0)     tmr_cnt = 8'hFE;
      else if (($urandom % 4) != 0) tmr_cnt = tmr_cnt + 8'd1;
      nmi_en    = 2'($urandom);
      ch0_en    = 6'($urandom);
      ch1_en    = 6'($urandom);
      misc_en   = 4'($urandom);
      cpu_imask = 1'($urandom);
      wr_en     = ($urandom % 3) == 0;
      wr_addr   = 2'($urandom);
      wr_data   = 8'($urandom);
      rd_addr   = 2'($urandom);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      // R2 R5 R6 R10 flags via read port
      chk("R2/R5/R6/R10 rd_data", rd_data, exp_rd(rd_addr));
      chk("R7 irq_sub", irq_sub, exp_sub());
      chk("R7 irq_req", irq_req, !cpu_imask && (exp_sub() != 0));
      chk("R8 nmi_req", nmi_req, m_nmi);
      chk("R9 vec_addr", vec_addr, (|(m_n & nmi_en)) ? 16'hFFFA : 16'hFFFE);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule